// File: doc/BRIEF.md
# Linked Descriptor Sequencer with Shared Trigger Flags

This block runs several independent channels, each of which walks a chain of four-word descriptors kept in a word-addressed memory. A channel is started with the word address of its first descriptor. It fetches the descriptor over a shared read port, carries it out, and then follows the descriptor's link to the next one. When it reaches a descriptor whose link flag is clear, the channel drops its busy flag and pulses done.

A descriptor is one of two kinds. A transfer descriptor is handed to an external data mover: the block holds a request with the source and destination words until the mover answers with a done strobe. A synchronization descriptor moves no data. It works only on a shared 8-bit trigger register. It can raise bits, lower bits, and stall its channel until chosen trigger bits reach chosen values. With these descriptors one channel can pause partway through its chain until a second channel releases it.

Descriptor layout, in word order from the descriptor's base address:
- Word 0, control: bit 0 is the kind (0 = transfer, 1 = sync).
- Word 1: the transfer source, or for a sync descriptor the set mask in [7:0] and the clear mask in [15:8].
- Word 2: the transfer destination, or for a sync descriptor the match-enable mask in [7:0] and the match value in [15:8].
- Word 3: the link. The flag is bit 0. Bits [31:2] hold the next descriptor's word address, so the word itself is that descriptor's byte address.

Top module: `desc_seq`

## Requirements
- R1: After reset the trigger register reads 0x00, every channel is idle (busy 0, done 0), no read is issued and no transfer request is raised.
- R2: A descriptor whose word 0 bit 0 is 0 raises that channel's transfer request, with source = word 1 and destination = word 2. The request and both words are held steady until the mover's done strobe is seen.
- R3: A descriptor whose word 0 bit 0 is 1 never raises the channel's transfer request.
- R4: A sync descriptor updates the trigger once, as new = (old AND NOT clear) OR set, with set = word 1 [7:0] and clear = word 1 [15:8]. A bit named in both masks ends up set. Updates from several channels in the same cycle are merged by the same rule. The trigger changes at no other time.
- R5: A sync descriptor stalls its channel until (trigger AND enable) equals (value AND enable), with enable = word 2 [7:0] and value = word 2 [15:8]. The test is made every cycle on the trigger value that includes that cycle's updates. An enable mask of 0 never stalls.
- R6: When word 3 bit 0 is 1, the channel next fetches the descriptor at word address word 3 [31:2]. When it is 0, the chain ends after this descriptor.
- R7: A descriptor fetch issues four reads on consecutive cycles, to word addresses base, base+1, base+2 and base+3. Read data is taken one cycle after each read.
- R8: Channels waiting to fetch share the read port through round-robin arbitration. At most one channel is granted at a time, and every requesting channel is eventually served.
- R9: When a descriptor with its link flag at 0 completes, done pulses for exactly one cycle and busy is low in that same cycle. A busy channel only goes idle through such a pulse.
- R10: A start on a channel that is busy is ignored. The running chain continues unchanged.
- R11: A channel stalled on a match wait resumes when another channel's sync update makes the match hold, and it then completes the rest of its chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_start | input | NCH | Per-channel start strobe |
| ch_start_addr | input | NCH*30 | Per-channel word address of the first descriptor |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 30 | Memory word address |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| xfer_req | output | NCH | Per-channel transfer request to the mover |
| xfer_src | output | NCH*32 | Per-channel transfer source word |
| xfer_dst | output | NCH*32 | Per-channel transfer destination word |
| xfer_done | input | NCH | Per-channel one-cycle completion strobe from the mover |
| ch_busy | output | NCH | Channel is running a chain |
| ch_done | output | NCH | One-cycle pulse at the end of a chain |
| trig_flags | output | 8 | Shared trigger register |

## Verification
The assertions assume that the memory always accepts a read and returns its word exactly one cycle later. They also assume that the mover strobes done for a single cycle, only while that channel's request is high, and that link addresses point at descriptor bases aligned to four words. The bench's memory model registers read data on the clock edge after each read. Its mover model counts a per-channel delay while the request is high, raises done for one cycle and then drops it, and every chain it builds uses four-aligned addresses.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  localparam int LINK_W = 30;
  localparam int WORD_W = 32;
  localparam int TRIG_W = 8;
  localparam int DESC_WORDS = 4;

  typedef struct packed {
    logic [WORD_W-1:0] link;
    logic [WORD_W-1:0] w2;
    logic [WORD_W-1:0] w1;
    logic [WORD_W-1:0] ctrl;
  } desc_t;

  typedef enum logic [2:0] {
    C_IDLE,
    C_FREQ,
    C_FWAIT,
    C_DEC,
    C_XFER,
    C_SWAIT
  } ch_state_t;

  function automatic logic [TRIG_W-1:0] trig_apply(
    input logic [TRIG_W-1:0] old_v,
    input logic [TRIG_W-1:0] set_m,
    input logic [TRIG_W-1:0] clr_m);
    return (old_v & ~clr_m) | set_m;
  endfunction

  function automatic logic sync_hit(
    input logic [TRIG_W-1:0] trig_v,
    input logic [TRIG_W-1:0] en_m,
    input logic [TRIG_W-1:0] val_m);
    return ((trig_v ^ val_m) & en_m) == '0;
  endfunction

  function automatic logic [LINK_W-1:0] link_target(input logic [LINK_W-1:0] field);
    return field;
  endfunction

endpackage

// File: rtl/dsq_trig.sv
module dsq_trig
  import dsq_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH*TRIG_W-1:0]   set_flat,
  input  logic [NCH*TRIG_W-1:0]   clr_flat,
  output logic [TRIG_W-1:0]       trig_q,
  output logic [TRIG_W-1:0]       trig_next
);

  logic [TRIG_W-1:0] set_all;
  logic [TRIG_W-1:0] clr_all;

  always_comb begin
    set_all = '0;
    clr_all = '0;
    for (int c = 0; c < NCH; c++) begin
      set_all = set_all | set_flat[c*TRIG_W +: TRIG_W];
      clr_all = clr_all | clr_flat[c*TRIG_W +: TRIG_W];
    end
    trig_next = trig_apply(trig_q, set_all, clr_all);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= '0;
    else        trig_q <= trig_next;
  end

endmodule

// File: rtl/dsq_fetch.sv
module dsq_fetch
  import dsq_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        req,
  input  logic [NCH*LINK_W-1:0] req_addr,
  output logic [NCH-1:0]        gnt,
  output logic                  mem_rd,
  output logic [LINK_W-1:0]     mem_addr,
  input  logic [WORD_W-1:0]     mem_rdata,
  output logic [NCH-1:0]        fdone,
  output desc_t                 fdesc,
  output logic                  rd_last
);

  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int IW = $clog2(DESC_WORDS);
  localparam logic [IW-1:0] LAST_IDX = IW'(DESC_WORDS - 1);

  logic                  active_q;
  logic                  issue_q;
  logic [IW-1:0]         cnt_q;
  logic                  cap_v_q;
  logic [IW-1:0]         cap_idx_q;
  logic [CW-1:0]         owner_q;
  logic [CW-1:0]         rr_q;
  logic [LINK_W-1:0]     base_q;
  logic [3*WORD_W-1:0]   words_q;
  logic [CW-1:0]         pick;
  logic                  found;
  logic                  fetch_end;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      int j;
      j = (int'(rr_q) + 1 + i) % NCH;
      if (!found && req[j]) begin
        found = 1'b1;
        pick  = CW'(j);
      end
    end
  end

  always_comb begin
    gnt = '0;
    if (!active_q && found) gnt[pick] = 1'b1;
  end

  assign mem_rd    = issue_q;
  assign mem_addr  = base_q + LINK_W'(cnt_q);
  assign rd_last   = issue_q && (cnt_q == LAST_IDX);
  assign fetch_end = cap_v_q && (cap_idx_q == LAST_IDX);
  assign fdesc     = {mem_rdata, words_q};

  always_comb begin
    fdone = '0;
    if (fetch_end) fdone[owner_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      issue_q   <= 1'b0;
      cnt_q     <= '0;
      cap_v_q   <= 1'b0;
      cap_idx_q <= '0;
      owner_q   <= '0;
      rr_q      <= CW'(NCH - 1);
      base_q    <= '0;
      words_q   <= '0;
    end else begin
      cap_v_q   <= issue_q;
      cap_idx_q <= cnt_q;
      if (!active_q && found) begin
        active_q <= 1'b1;
        issue_q  <= 1'b1;
        cnt_q    <= '0;
        owner_q  <= pick;
        rr_q     <= pick;
        base_q   <= req_addr[int'(pick)*LINK_W +: LINK_W];
      end else if (issue_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST_IDX) issue_q <= 1'b0;
      end
      if (cap_v_q) words_q <= {mem_rdata, words_q[3*WORD_W-1:WORD_W]};
      if (fetch_end) active_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dsq_chan.sv
module dsq_chan
  import dsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LINK_W-1:0] start_addr,
  output logic              fetch_req,
  output logic [LINK_W-1:0] fetch_addr,
  input  logic              fetch_gnt,
  input  logic              fetch_done,
  input  desc_t             fetch_desc,
  input  logic [TRIG_W-1:0] trig_next,
  output logic [TRIG_W-1:0] set_mask,
  output logic [TRIG_W-1:0] clr_mask,
  output logic              apply,
  output logic              in_sync,
  output logic              xfer_req,
  output logic [WORD_W-1:0] xfer_src,
  output logic [WORD_W-1:0] xfer_dst,
  input  logic              xfer_done,
  output logic              busy,
  output logic              done
);

  ch_state_t         state_q;
  desc_t             desc_q;
  logic [LINK_W-1:0] addr_q;
  logic              done_q;
  logic              is_sync;
  logic              link_on;
  logic              hit;
  logic              advance;
  logic              unused_bits;

  assign is_sync  = desc_q.ctrl[0];
  assign link_on  = desc_q.link[0];
  assign unused_bits = ^{desc_q.ctrl[WORD_W-1:1], desc_q.link[1]};

  assign apply    = (state_q == C_DEC) && is_sync;
  assign set_mask = apply ? desc_q.w1[TRIG_W-1:0] : '0;
  assign clr_mask = apply ? desc_q.w1[2*TRIG_W-1:TRIG_W] : '0;
  assign hit      = sync_hit(trig_next, desc_q.w2[TRIG_W-1:0], desc_q.w2[2*TRIG_W-1:TRIG_W]);
  assign in_sync  = apply || (state_q == C_SWAIT);
  assign advance  = (in_sync && hit) || ((state_q == C_XFER) && xfer_done);

  assign fetch_req  = (state_q == C_FREQ);
  assign fetch_addr = addr_q;
  assign xfer_req   = (state_q == C_XFER);
  assign xfer_src   = desc_q.w1;
  assign xfer_dst   = desc_q.w2;
  assign busy       = (state_q != C_IDLE);
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= C_IDLE;
      desc_q  <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        C_IDLE:  if (start) begin
                   addr_q  <= start_addr;
                   state_q <= C_FREQ;
                 end
        C_FREQ:  if (fetch_gnt) state_q <= C_FWAIT;
        C_FWAIT: if (fetch_done) begin
                   desc_q  <= fetch_desc;
                   state_q <= C_DEC;
                 end
        C_DEC:   if (!is_sync) state_q <= C_XFER;
                 else if (!hit) state_q <= C_SWAIT;
        default: ;
      endcase
      if (advance) begin
        if (link_on) begin
          addr_q  <= link_target(desc_q.link[WORD_W-1:2]);
          state_q <= C_FREQ;
        end else begin
          done_q  <= 1'b1;
          state_q <= C_IDLE;
        end
      end
    end
  end

endmodule

// File: rtl/desc_seq.sv
module desc_seq
  import dsq_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        ch_start,
  input  logic [NCH*LINK_W-1:0] ch_start_addr,
  output logic                  mem_rd,
  output logic [LINK_W-1:0]     mem_addr,
  input  logic [WORD_W-1:0]     mem_rdata,
  output logic [NCH-1:0]        xfer_req,
  output logic [NCH*WORD_W-1:0] xfer_src,
  output logic [NCH*WORD_W-1:0] xfer_dst,
  input  logic [NCH-1:0]        xfer_done,
  output logic [NCH-1:0]        ch_busy,
  output logic [NCH-1:0]        ch_done,
  output logic [TRIG_W-1:0]     trig_flags
);

  logic [NCH-1:0]        fetch_req;
  logic [NCH*LINK_W-1:0] fetch_addr;
  logic [NCH-1:0]        fetch_gnt;
  logic [NCH-1:0]        fetch_done;
  desc_t                 fetch_desc;
  logic                  rd_last;
  logic [NCH*TRIG_W-1:0] set_flat;
  logic [NCH*TRIG_W-1:0] clr_flat;
  logic [NCH-1:0]        apply_vec;
  logic [NCH-1:0]        in_sync_vec;
  logic [TRIG_W-1:0]     trig_next;

  dsq_trig #(.NCH(NCH)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_flat  (set_flat),
    .clr_flat  (clr_flat),
    .trig_q    (trig_flags),
    .trig_next (trig_next)
  );

  dsq_fetch #(.NCH(NCH)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (fetch_req),
    .req_addr  (fetch_addr),
    .gnt       (fetch_gnt),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .fdone     (fetch_done),
    .fdesc     (fetch_desc),
    .rd_last   (rd_last)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dsq_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (ch_start[c]),
      .start_addr (ch_start_addr[c*LINK_W +: LINK_W]),
      .fetch_req  (fetch_req[c]),
      .fetch_addr (fetch_addr[c*LINK_W +: LINK_W]),
      .fetch_gnt  (fetch_gnt[c]),
      .fetch_done (fetch_done[c]),
      .fetch_desc (fetch_desc),
      .trig_next  (trig_next),
      .set_mask   (set_flat[c*TRIG_W +: TRIG_W]),
      .clr_mask   (clr_flat[c*TRIG_W +: TRIG_W]),
      .apply      (apply_vec[c]),
      .in_sync    (in_sync_vec[c]),
      .xfer_req   (xfer_req[c]),
      .xfer_src   (xfer_src[c*WORD_W +: WORD_W]),
      .xfer_dst   (xfer_dst[c*WORD_W +: WORD_W]),
      .xfer_done  (xfer_done[c]),
      .busy       (ch_busy[c]),
      .done       (ch_done[c])
    );
  end

endmodule

// File: rtl/desc_seq_chk.sv
module desc_seq_chk
  import dsq_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [TRIG_W-1:0]     trig_flags,
  input logic [NCH-1:0]        apply_vec,
  input logic [NCH-1:0]        in_sync_vec,
  input logic [NCH-1:0]        fetch_gnt,
  input logic                  mem_rd,
  input logic [LINK_W-1:0]     mem_addr,
  input logic                  rd_last,
  input logic [NCH-1:0]        xfer_req,
  input logic [NCH*WORD_W-1:0] xfer_src,
  input logic [NCH-1:0]        xfer_done,
  input logic [NCH-1:0]        ch_busy,
  input logic [NCH-1:0]        ch_done
);

  p_trig_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(|apply_vec) |=> $stable(trig_flags));

  p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fetch_gnt));

  p_burst_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !rd_last) |=> (mem_rd && (mem_addr == $past(mem_addr) + 1'b1)));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req[c] && !xfer_done[c]) |=>
        (xfer_req[c] && $stable(xfer_src[c*WORD_W +: WORD_W])));

    p_sync_no_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_sync_vec[c] |-> !xfer_req[c]);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ch_done[c] |-> !ch_busy[c]);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ch_done[c] |=> !ch_done[c]);

    p_leave_by_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ch_busy[c] |=> (ch_busy[c] || ch_done[c]));
  end

endmodule

bind desc_seq desc_seq_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trig_flags  (trig_flags),
  .apply_vec   (apply_vec),
  .in_sync_vec (in_sync_vec),
  .fetch_gnt   (fetch_gnt),
  .mem_rd      (mem_rd),
  .mem_addr    (mem_addr),
  .rd_last     (rd_last),
  .xfer_req    (xfer_req),
  .xfer_src    (xfer_src),
  .xfer_done   (xfer_done),
  .ch_busy     (ch_busy),
  .ch_done     (ch_done)
);

// File: tb/desc_seq_test.sv
module desc_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int NVEC = 6;
  // each vector: {set mask, clear mask, expected trigger afterwards}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h81_00_81, 24'h0F_01_8F, 24'h00_F0_0F,
    24'h30_3C_33, 24'hA5_00_B7, 24'h00_FF_00
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] ch_start = '0;
  logic [NCH*30-1:0] ch_start_addr = '0;
  logic mem_rd;
  logic [29:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [NCH-1:0] xfer_req;
  logic [NCH*32-1:0] xfer_src;
  logic [NCH*32-1:0] xfer_dst;
  logic [NCH-1:0] xfer_done = '0;
  logic [NCH-1:0] ch_busy;
  logic [NCH-1:0] ch_done;
  logic [7:0] trig_flags;

  logic [31:0] mem [64];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  int mv_cnt [NCH];
  int mv_dly [NCH];
  int lg_n [NCH];
  logic [31:0] lg_src [NCH][8];
  logic [31:0] lg_dst [NCH][8];
  int dn_n [NCH];
  int dn_cyc [NCH];
  int viol = 0;
  int rdl_n = 0;
  logic [29:0] rdl [4];
  bit finished = 1'b0;

  desc_seq #(.NCH(NCH)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];

  always @(negedge clk) begin
    cyc++;
    if (rst_n && mem_rd && rdl_n < 4) begin
      rdl[rdl_n] = mem_addr;
      rdl_n++;
    end
    for (int c = 0; c < NCH; c++) begin
      if (ch_done[c]) begin
        dn_n[c]++;
        dn_cyc[c] = cyc;
        if (ch_busy[c]) viol++;
      end
      if (xfer_done[c]) begin
        xfer_done[c] = 1'b0;
        mv_cnt[c] = 0;
      end else if (xfer_req[c]) begin
        mv_cnt[c]++;
        if (mv_cnt[c] >= mv_dly[c]) begin
          xfer_done[c] = 1'b1;
          lg_src[c][lg_n[c] & 7] = xfer_src[c*32 +: 32];
          lg_dst[c][lg_n[c] & 7] = xfer_dst[c*32 +: 32];
          lg_n[c]++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic put_desc(input int base, input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3);
    mem[base] = w0; mem[base+1] = w1; mem[base+2] = w2; mem[base+3] = w3;
  endtask

  task automatic start_mask(input logic [NCH-1:0] m, input logic [29:0] a0, input logic [29:0] a1);
    @(negedge clk);
    ch_start = m;
    ch_start_addr = {a1, a0};
    @(negedge clk);
    ch_start = '0;
    #1;
  endtask

  task automatic wait_done(input int c, input int target, input string req);
    int n = 0;
    while (dn_n[c] < target && n < 500) begin
      tick(1);
      n++;
    end
    check(dn_n[c] >= target, req, 32'(dn_n[c]), 32'(target));
  endtask

  initial begin
    int base0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    for (int c = 0; c < NCH; c++) begin
      mv_cnt[c] = 0; mv_dly[c] = 2; lg_n[c] = 0; dn_n[c] = 0; dn_cyc[c] = 0;
    end
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1: reset state
    check(trig_flags == 8'h00, "R1 trigger", 32'(trig_flags), 32'h0);
    check(ch_busy == '0 && ch_done == '0, "R1 idle", 32'({ch_busy, ch_done}), 32'h0);
    check(!mem_rd && xfer_req == '0, "R1 quiet", 32'({mem_rd, xfer_req}), 32'h0);

    // R4: table of sync updates, each run as a one-descriptor chain on channel 0
    for (int k = 0; k < NVEC; k++) begin
      put_desc(32, 32'h1, {16'h0, VEC[k][15:8], VEC[k][23:16]}, 32'h0, 32'h0);
      start_mask(2'b01, 30'd32, 30'd0);
      wait_done(0, k + 1, "R9 table chain end");
      check(trig_flags == VEC[k][7:0], "R4 trigger update", 32'(trig_flags), 32'(VEC[k][7:0]));
      if (k == 0) begin
        check(rdl_n == 4 && rdl[0] == 30'd32 && rdl[1] == 30'd33 && rdl[2] == 30'd34 && rdl[3] == 30'd35,
              "R7 read burst", 32'(rdl[3]), 32'd35);
      end
    end
    check(lg_n[0] == 0, "R3 sync moves no data", 32'(lg_n[0]), 32'h0);

    // R5 R6 R11: channel 0 waits between two transfers for channel 1's release
    put_desc(0,  32'h0, 32'h1000_00A0, 32'h2000_00A0, 32'h0000_0011);
    put_desc(4,  32'h1, 32'h0,         32'h0000_8080, 32'h0000_0021);
    put_desc(8,  32'h0, 32'h1000_00C0, 32'h2000_00C0, 32'h0);
    put_desc(12, 32'h0, 32'h1000_00B0, 32'h2000_00B0, 32'h0000_0041);
    put_desc(16, 32'h1, 32'h0000_0080, 32'h0,         32'h0);
    put_desc(20, 32'h0, 32'hDEAD_0000, 32'hDEAD_0001, 32'h0);
    mv_dly[0] = 2;
    mv_dly[1] = 40;
    base0 = dn_n[0];
    start_mask(2'b11, 30'd0, 30'd12);
    begin
      int n = 0;
      while (lg_n[0] < 1 && n < 200) begin tick(1); n++; end
    end
    tick(15);
    check(ch_busy[0] && !xfer_req[0] && lg_n[0] == 1, "R5 stall on wait",
          32'({ch_busy[0], xfer_req[0]}), 32'h2);
    check(trig_flags == 8'h00, "R5 trigger untouched", 32'(trig_flags), 32'h0);
    check(ch_busy[1] && xfer_req[1], "R8 second channel served", 32'({ch_busy[1], xfer_req[1]}), 32'h3);
    // R10: start while busy
    start_mask(2'b01, 30'd20, 30'd0);
    wait_done(0, base0 + 1, "R11 stalled chain completes");
    check(dn_n[1] == 1 && dn_cyc[0] > dn_cyc[1], "R11 release order", 32'(dn_cyc[0]), 32'(dn_cyc[1]));
    check(lg_n[0] == 2 && lg_src[0][0] == 32'h1000_00A0 && lg_src[0][1] == 32'h1000_00C0,
          "R6 linked chain src", lg_src[0][1], 32'h1000_00C0);
    check(lg_dst[0][1] == 32'h2000_00C0, "R2 transfer dst", lg_dst[0][1], 32'h2000_00C0);
    check(lg_n[1] == 1 && lg_src[1][0] == 32'h1000_00B0, "R3 R2 channel 1 moves once",
          lg_src[1][0], 32'h1000_00B0);
    check(trig_flags == 8'h80, "R4 release set", 32'(trig_flags), 32'h80);
    tick(5);
    check(dn_n[0] == base0 + 1 && !ch_busy[0], "R10 busy start ignored", 32'(dn_n[0]), 32'(base0 + 1));

    // R5: wait for bit 0 high and bit 7 low, released by the other channel
    put_desc(24, 32'h1, 32'h0, 32'h0000_0181, 32'h0);
    put_desc(28, 32'h1, 32'h0000_8001, 32'h0, 32'h0);
    start_mask(2'b10, 30'd0, 30'd24);
    tick(20);
    check(ch_busy[1] && dn_n[1] == 1, "R5 waits on mixed match", 32'(dn_n[1]), 32'h1);
    start_mask(2'b01, 30'd28, 30'd0);
    wait_done(1, 2, "R11 clear releases wait");
    check(trig_flags == 8'h01, "R4 set and clear", 32'(trig_flags), 32'h01);
    check(viol == 0, "R9 done while busy", 32'(viol), 32'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (cyc < 100000) @(negedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule